// File: doc/BRIEF.md
# Host direct-access arbiter with retry

This block decides, cycle by cycle, whether a host register access may use a local bus that a DMA engine may currently be driving. When nothing holds the bus, or when a write transfer has already handed the bus back and only its FIFO is still emptying toward the host, the access is accepted at once. When the DMA engine does hold the bus, the block raises a pause request to the local processor. It then answers each host attempt with a retry until the processor confirms that the bus is free.

The first host attempt after that confirmation is accepted. The pause request stays up through the accept cycle and drops in the cycle after it, which lets the DMA transfer resume. Only one host access is served per pause. Any further attempt while the pause is winding down is retried and starts a fresh arbitration later. Responses are registered: the accept or retry pulse for an attempt appears in the clock cycle after the attempt is sampled.

Top module: `hda_arbiter`

## Requirements
- R1: After reset, `host_ack`, `host_retry` and `lbus_pause` are all 0.
- R2: With `lbus_pause` low and `dma_run` low, a sampled `host_req` gives `host_ack` = 1 in the next cycle, and the pause stays low.
- R3: With `lbus_pause` low, `dma_run` = 1 and `wr_tail` = 1 (the write FIFO is draining and the local bus is already released), a sampled `host_req` gives `host_ack` = 1 in the next cycle, with no retry and no pause.
- R4: With `lbus_pause` low, `dma_run` = 1 and `wr_tail` = 0, a sampled `host_req` gives `host_retry` = 1 and `lbus_pause` = 1 in the next cycle.
- R5: While the pause waits for release, every sampled `host_req` with `rel_ack` = 0 gives `host_retry` = 1 in the next cycle, and `lbus_pause` stays 1.
- R6: While the pause waits for release, a sampled `host_req` with `rel_ack` = 1 gives `host_ack` = 1 in the next cycle with `lbus_pause` still 1. `lbus_pause` is 0 in the cycle after that (default `PAUSE_HOLD` = 1).
- R7: A `host_req` sampled in the cycle in which the single serviced access is being accepted is answered with `host_retry` = 1.
- R8: `host_ack` and `host_retry` are never 1 together, and neither is 1 in a cycle after a cycle in which `host_req` was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host direct-access attempt in this cycle |
| dma_run | input | 1 | A DMA transfer is in progress |
| wr_tail | input | 1 | Write transfer has freed the local bus; FIFO still draining |
| rel_ack | input | 1 | Local processor confirms it has released the local bus |
| host_ack | output | 1 | Attempt accepted (pulse, cycle after the attempt) |
| host_retry | output | 1 | Attempt must be retried (pulse, cycle after the attempt) |
| lbus_pause | output | 1 | Pause request to the local processor |

## Verification
The arbiter is driven with attempts on a quiet bus, attempts during a draining write tail, and attempts while a transfer holds the bus. These separate immediate acceptance from the pause path. Inside a pause, attempts are repeated with release withheld, then release is given both before and together with the next attempt. An extra attempt is placed in the accept cycle. This tells apart retry-until-release, single-access service and the exact drop cycle of the pause. Idle cycles between attempts show that no response appears without a request.

// File: rtl/hda_pkg.sv
package hda_pkg;
   typedef enum logic [1:0] {
      ST_FREE = 2'd0,
      ST_WAIT = 2'd1,
      ST_HOLD = 2'd2
   } hda_state_e;

   typedef enum logic [1:0] {
      DEC_NONE   = 2'd0,
      DEC_ACCEPT = 2'd1,
      DEC_RETRY  = 2'd2
   } hda_dec_e;
endpackage

// File: rtl/hda_decide.sv
module hda_decide
   import hda_pkg::*;
(
   input  hda_state_e state,
   input  logic       host_req,
   input  logic       bus_held,
   input  logic       rel_ack,
   output hda_dec_e   dec
);
   always_comb begin
      dec = DEC_NONE;
      if (host_req) begin
         unique case (state)
            ST_FREE: dec = bus_held ? DEC_RETRY : DEC_ACCEPT;
            ST_WAIT: dec = rel_ack ? DEC_ACCEPT : DEC_RETRY;
            ST_HOLD: dec = DEC_RETRY;
            default: dec = DEC_RETRY;
         endcase
      end
   end
endmodule

// File: rtl/hda_seq.sv
module hda_seq
   import hda_pkg::*;
#(
   parameter int PAUSE_HOLD = 1
)(
   input  logic       clk,
   input  logic       rst_n,
   input  hda_dec_e   dec,
   output hda_state_e state,
   output logic       pause
);
   localparam int CW = (PAUSE_HOLD > 1) ? $clog2(PAUSE_HOLD) : 1;

   if (PAUSE_HOLD < 1) begin : g_bad_hold
      $error("PAUSE_HOLD must be at least 1");
   end

   logic [CW-1:0] hold_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_FREE;
         hold_cnt <= '0;
      end else begin
         unique case (state)
            ST_FREE: if (dec == DEC_RETRY) state <= ST_WAIT;
            ST_WAIT: if (dec == DEC_ACCEPT) begin
               state    <= ST_HOLD;
               hold_cnt <= CW'(PAUSE_HOLD - 1);
            end
            ST_HOLD: begin
               if (hold_cnt == '0) state <= ST_FREE;
               else                hold_cnt <= hold_cnt - 1'b1;
            end
            default: state <= ST_FREE;
         endcase
      end
   end

   assign pause = (state != ST_FREE);

   p_hold_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HOLD && hold_cnt == '0) |=> (state == ST_FREE));
endmodule

// File: rtl/hda_arbiter.sv
module hda_arbiter
   import hda_pkg::*;
#(
   parameter int PAUSE_HOLD = 1
)(
   input  logic clk,
   input  logic rst_n,
   input  logic host_req,
   input  logic dma_run,
   input  logic wr_tail,
   input  logic rel_ack,
   output logic host_ack,
   output logic host_retry,
   output logic lbus_pause
);
   hda_state_e state;
   hda_dec_e   dec;
   logic       bus_held;

   assign bus_held = dma_run & ~wr_tail;

   hda_decide u_decide (
      .state    (state),
      .host_req (host_req),
      .bus_held (bus_held),
      .rel_ack  (rel_ack),
      .dec      (dec)
   );

   hda_seq #(.PAUSE_HOLD(PAUSE_HOLD)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .dec   (dec),
      .state (state),
      .pause (lbus_pause)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         host_ack   <= 1'b0;
         host_retry <= 1'b0;
      end else begin
         host_ack   <= (dec == DEC_ACCEPT);
         host_retry <= (dec == DEC_RETRY);
      end
   end

   p_free_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!lbus_pause && host_req && !dma_run) |=> (host_ack && !lbus_pause));
   p_tail_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!lbus_pause && host_req && dma_run && wr_tail) |=> (host_ack && !host_retry && !lbus_pause));
   p_enter_pause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!lbus_pause && host_req && dma_run && !wr_tail) |=> (host_retry && lbus_pause));
   p_retry_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && host_req && !rel_ack) |=> (host_retry && lbus_pause));
   p_accept_regain_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && host_req && rel_ack) |=> (host_ack && lbus_pause));
   p_second_retry_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HOLD && host_req) |=> host_retry);
   p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_ack && host_retry));
   p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !host_req |=> (!host_ack && !host_retry));

   if (PAUSE_HOLD == 1) begin : g_drop_chk
      p_pause_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (host_ack && lbus_pause) |=> !lbus_pause);
   end
endmodule

// File: tb/hda_arbiter_tb_top.sv
module hda_arbiter_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_req = 1'b0, dma_run = 1'b0, wr_tail = 1'b0, rel_ack = 1'b0;
   logic host_ack, host_retry, lbus_pause;

   int total = 0, fails = 0, cycles = 0;
   bit done = 0;
   string cur_tag = "R1";

   always #4 clk = ~clk;

   hda_arbiter dut_i (
      .clk(clk), .rst_n(rst_n), .host_req(host_req), .dma_run(dma_run),
      .wr_tail(wr_tail), .rel_ack(rel_ack), .host_ack(host_ack),
      .host_retry(host_retry), .lbus_pause(lbus_pause));

   // behavioural reference
   bit m_paused = 0, m_served = 0, e_ack = 0, e_retry = 0;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_paused = 0; m_served = 0; e_ack = 0; e_retry = 0;
      end else begin
         e_ack = 0; e_retry = 0;
         if (m_served) begin
            if (host_req) e_retry = 1;
            m_served = 0; m_paused = 0;
         end else if (m_paused) begin
            if (host_req) begin
               if (rel_ack) begin e_ack = 1; m_served = 1; end
               else e_retry = 1;
            end
         end else if (host_req) begin
            if (dma_run && !wr_tail) begin e_retry = 1; m_paused = 1; end
            else e_ack = 1;
         end
      end
   end

   task automatic chk(input string what, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0b expected=%0b", cur_tag, what, act, exp);
      end
   endtask

   task automatic compare();
      chk("host_ack", host_ack, e_ack);
      chk("host_retry", host_retry, e_retry);
      chk("lbus_pause", lbus_pause, m_paused || m_served);
      if (host_ack && host_retry) chk("R8 exclusive", 1'b1, 1'b0);
   endtask

   task automatic cyc(input logic rq, input logic run, input logic tail,
                      input logic ra, input string tag);
      host_req = rq; dma_run = run; wr_tail = tail; rel_ack = ra; cur_tag = tag;
      @(posedge clk);
      @(negedge clk);
      compare();
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000 && !done) begin
         done = 1;
         total++; fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      @(negedge clk); @(negedge clk);
      cur_tag = "R1";
      chk("reset host_ack", host_ack, 1'b0);
      chk("reset host_retry", host_retry, 1'b0);
      chk("reset lbus_pause", lbus_pause, 1'b0);
      rst_n = 1'b1;
      cyc(0, 0, 0, 0, "R1");
      // quiet bus
      cyc(1, 0, 0, 0, "R2");
      cyc(1, 0, 0, 0, "R2");
      cyc(0, 0, 0, 0, "R8");
      cyc(1, 0, 0, 0, "R2");
      cyc(0, 0, 0, 0, "R8");
      // draining write tail
      cyc(0, 1, 1, 0, "R8");
      cyc(1, 1, 1, 0, "R3");
      cyc(1, 1, 1, 0, "R3");
      cyc(0, 1, 1, 0, "R8");
      // transfer holds bus
      cyc(0, 1, 0, 0, "R8");
      cyc(1, 1, 0, 0, "R4");
      cyc(1, 1, 0, 0, "R5");
      cyc(0, 1, 0, 0, "R5");
      cyc(1, 1, 0, 0, "R5");
      cyc(1, 1, 0, 0, "R5");
      cyc(1, 1, 0, 1, "R6");
      cyc(1, 0, 0, 1, "R7");
      cyc(0, 0, 0, 0, "R6");
      cyc(0, 1, 0, 0, "R8");
      // release arrives before the next attempt
      cyc(1, 1, 0, 0, "R4");
      cyc(0, 1, 0, 1, "R6");
      cyc(0, 0, 0, 1, "R6");
      cyc(1, 0, 0, 1, "R6");
      cyc(0, 0, 0, 0, "R6");
      cyc(0, 1, 0, 0, "R8");
      // immediate re-pause after service
      cyc(1, 1, 0, 0, "R4");
      cyc(1, 0, 0, 1, "R6");
      cyc(1, 1, 0, 0, "R7");
      cyc(1, 1, 0, 0, "R4");
      cyc(1, 0, 0, 1, "R6");
      cyc(0, 0, 0, 0, "R6");
      cyc(0, 0, 0, 0, "R8");
      // reset mid-pause
      cyc(1, 1, 0, 0, "R4");
      rst_n = 1'b0;
      cyc(0, 1, 0, 0, "R1");
      rst_n = 1'b1;
      cyc(0, 0, 0, 0, "R1");
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end
endmodule